// File: doc/BRIEF.md
# Big-Endian Sub-Word Load/Store Aligner

This unit sits between a 32-bit core and a data memory that is one word wide. On a store it turns an access size, the two low address bits and the core's store data into per-byte write strobes and a write word with the store value copied onto every lane it could land on. On a load it takes the word returned by memory, picks out the addressed byte or half-word and widens it to 32 bits, filling the upper bits with either copies of the value's top bit or with zeros, as the instruction selects.

Byte lanes are numbered big-endian: byte offset 0 is the most significant byte of the word. Every access must be aligned to its own size. An access that is not aligned, or that uses the reserved size code, raises an address-error output, and then no strobe fires and the load result is zero. The caller computes the effective address and presents a returned read word together with the attributes of the load it belongs to. All outputs are registered and appear on the clock edge after the request.

Top module: `ba_lsu_aligner`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output goes to zero at that edge.
- R2: An aligned byte store (`req_size`=0) sets exactly one strobe: offset k sets `wr_en[3-k]`, and `wr_en[3]` covers bits 31:24.
- R3: A half-word store (`req_size`=1) at offset 0 sets `wr_en`=4'b1100; at offset 2 it sets 4'b0011.
- R4: A word store (`req_size`=2) at offset 0 sets `wr_en`=4'b1111.
- R5: `wr_data` holds the low byte of `st_data` copied into all four lanes when `req_size`=0, the low half-word copied twice when `req_size`=1, and `st_data` unchanged otherwise. This holds whatever the other request inputs are.
- R6: A valid access is in error when it is a half-word with offset bit 0 set, a word with a non-zero offset, or uses `req_size`=3. Such an access sets `addr_err`=1, `wr_en`=0 and `ld_data`=0.
- R7: A signed byte load (`req_unsigned`=0) returns the byte at bits [31-8k -: 8] of `rd_word`, with bits 31:8 copied from its bit 7. A signed half-word load does the same with its bit 15.
- R8: An unsigned load (`req_unsigned`=1) of a byte or a half-word clears every bit above the loaded value.
- R9: A half-word load at offset 0 takes `rd_word[31:16]`, and at offset 2 it takes `rd_word[15:0]`. An aligned word load returns `rd_word` unchanged.
- R10: Outputs reflect the request one clock edge later. With `req_valid`=0, `wr_en`, `addr_err` and `ld_data` are zero.
- R11: A load (`req_is_store`=0) never sets any bit of `wr_en`. A store returns `ld_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| req_unsigned | input | 1 | Zero-extend a loaded byte or half-word |
| req_offset | input | 2 | Low two bits of the effective address |
| st_data | input | 32 | Store value, right-aligned |
| rd_word | input | 32 | Word returned by memory for this load |
| wr_en | output | 4 | Byte strobes; bit 3 covers bits 31:24 |
| wr_data | output | 32 | Store value copied onto its lanes |
| ld_data | output | 32 | Extended load result |
| addr_err | output | 1 | Misaligned or reserved-size access |

## Verification
The assertions take for granted that each request input is held steady from one clock edge until the next edge samples it. They also assume that `rd_word` belongs to the load being presented, so a result one edge later can be traced to the request that produced it. The bench changes inputs only on falling edges and holds every request for a full cycle. Its random requests cover all size codes, offsets and sign choices, including reserved and misaligned ones, so error cases occur alongside legal ones.

// File: rtl/ba_lsu_pkg.sv
// Shared definitions for the sub-word load/store aligner.
// Assumes byte lanes of eight bits.
package ba_lsu_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    localparam int LANE_W = 8;
endpackage

// File: rtl/ba_align_check.sv
// Decides whether an access of a given size at a given byte offset is
// illegal. Illegal means not a multiple of its own size, or the reserved
// size code. Purely combinational.
module ba_align_check #(
    parameter int OFF_W = 2
) (
    input  logic [1:0]       size,
    input  logic [OFF_W-1:0] offset,
    output logic             misalign
);
    import ba_lsu_pkg::*;

    // classify the access by its size code
    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: misalign = 1'b0;
            SZ_HALF: misalign = offset[0];
            SZ_WORD: misalign = |offset;
            default: misalign = 1'b1;
        endcase
    end
endmodule

// File: rtl/ba_store_lanes.sv
// Builds the byte strobes and the lane-replicated write word for a store.
// Lane k is byte offset k; it sits at bits [DATA_W-1-8k -: 8] (big-endian)
// and is enabled by strobe bit BYTES-1-k. Assumes the caller gates 'en'
// with alignment. Combinational.
module ba_store_lanes #(
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES)
) (
    input  logic              en,
    input  logic [1:0]        size,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] data,
    output logic [BYTES-1:0]  we,
    output logic [DATA_W-1:0] wdata
);
    import ba_lsu_pkg::*;

    for (genvar k = 0; k < BYTES; k++) begin : g_lane
        localparam int HI = DATA_W - 1 - LANE_W * k;
        localparam logic [OFF_W-1:0] K = OFF_W'(k);
        logic hit;

        // does this lane belong to the addressed item
        always_comb begin
            unique case (acc_size_e'(size))
                SZ_BYTE: hit = (offset == K);
                SZ_HALF: hit = (offset[OFF_W-1:1] == K[OFF_W-1:1]);
                default: hit = 1'b1;
            endcase
        end

        // strobe for this lane, big-endian bit position
        assign we[BYTES-1-k] = en & hit;

        // value this lane carries for each size
        always_comb begin
            unique case (acc_size_e'(size))
                SZ_BYTE: wdata[HI -: LANE_W] = data[LANE_W-1:0];
                SZ_HALF: wdata[HI -: LANE_W] = K[0] ? data[LANE_W-1:0]
                                                    : data[2*LANE_W-1:LANE_W];
                default: wdata[HI -: LANE_W] = data[HI -: LANE_W];
            endcase
        end
    end
endmodule

// File: rtl/ba_load_extend.sv
// Picks the addressed byte or half-word out of a read word (big-endian
// lanes) and sign- or zero-extends it. A word passes through. Output is
// zero when 'en' is low. Combinational.
module ba_load_extend #(
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES)
) (
    input  logic              en,
    input  logic [1:0]        size,
    input  logic [OFF_W-1:0]  offset,
    input  logic              is_unsigned,
    input  logic [DATA_W-1:0] rword,
    output logic [DATA_W-1:0] value
);
    import ba_lsu_pkg::*;

    logic [LANE_W-1:0]   lane [BYTES];
    logic [LANE_W-1:0]   sel_b;
    logic [2*LANE_W-1:0] sel_h;
    logic [OFF_W-1:0]    h_hi, h_lo;

    for (genvar k = 0; k < BYTES; k++) begin : g_lane
        assign lane[k] = rword[DATA_W-1-LANE_W*k -: LANE_W];
    end

    assign h_hi  = {offset[OFF_W-1:1], 1'b0};
    assign h_lo  = {offset[OFF_W-1:1], 1'b1};
    assign sel_b = lane[offset];
    assign sel_h = {lane[h_hi], lane[h_lo]};

    // widen the selected item
    always_comb begin
        value = '0;
        if (en) begin
            unique case (acc_size_e'(size))
                SZ_BYTE: value = {{(DATA_W-LANE_W){~is_unsigned & sel_b[LANE_W-1]}}, sel_b};
                SZ_HALF: value = {{(DATA_W-2*LANE_W){~is_unsigned & sel_h[2*LANE_W-1]}}, sel_h};
                default: value = rword;
            endcase
        end
    end
endmodule

// File: rtl/ba_lsu_aligner.sv
// Top of the big-endian sub-word aligner. Combines the alignment check,
// store lane builder and load extender, and registers all outputs one
// edge after the request. Assumes rd_word arrives with the attributes of
// its own load. Synchronous active-low reset.
module ba_lsu_aligner #(
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_store,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [DATA_W-1:0] st_data,
    input  logic [DATA_W-1:0] rd_word,
    output logic [BYTES-1:0]  wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] ld_data,
    output logic              addr_err
);
    logic              misalign;
    logic              st_go, ld_go;
    logic [BYTES-1:0]  we_c;
    logic [DATA_W-1:0] wd_c, ld_c;

    ba_align_check #(.OFF_W(OFF_W)) u_align (
        .size     (req_size),
        .offset   (req_offset),
        .misalign (misalign)
    );

    assign st_go = req_valid &  req_is_store & ~misalign;
    assign ld_go = req_valid & ~req_is_store & ~misalign;

    ba_store_lanes #(.DATA_W(DATA_W)) u_store (
        .en     (st_go),
        .size   (req_size),
        .offset (req_offset),
        .data   (st_data),
        .we     (we_c),
        .wdata  (wd_c)
    );

    ba_load_extend #(.DATA_W(DATA_W)) u_load (
        .en          (ld_go),
        .size        (req_size),
        .offset      (req_offset),
        .is_unsigned (req_unsigned),
        .rword       (rd_word),
        .value       (ld_c)
    );

    // output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en    <= '0;
            wr_data  <= '0;
            ld_data  <= '0;
            addr_err <= 1'b0;
        end else begin
            wr_en    <= we_c;
            wr_data  <= wd_c;
            ld_data  <= ld_c;
            addr_err <= req_valid & misalign;
        end
    end
endmodule

// File: rtl/ba_lsu_aligner_chk.sv
// Property checker for ba_lsu_aligner, attached by bind. Assumes request
// inputs are stable across each sampling edge.
module ba_lsu_aligner_chk #(
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_is_store,
    input logic [1:0]        req_size,
    input logic              req_unsigned,
    input logic [OFF_W-1:0]  req_offset,
    input logic [BYTES-1:0]  wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] ld_data,
    input logic              addr_err
);
    // R2
    byte_one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_store && req_size == 2'd0) |=> ($countones(wr_en) == 1));

    // R3
    half_low_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_store && req_size == 2'd1 && req_offset == 2'd2)
        |=> (wr_en == 4'b0011));

    // R4
    word_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_store && req_size == 2'd2 && req_offset == 2'd0)
        |=> (wr_en == 4'b1111));

    // R5
    byte_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_size == 2'd0) |=> (wr_data[31:24] == wr_data[7:0] && wr_data[15:8] == wr_data[23:16]
                                && wr_data[15:8] == wr_data[7:0]));

    // R6
    err_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> (wr_en == '0 && ld_data == '0));

    // R7
    signed_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_store && req_size == 2'd0 && !req_unsigned)
        |=> (ld_data[31:8] == {24{ld_data[7]}}));

    // R8
    unsigned_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_store && req_size == 2'd1 && req_unsigned)
        |=> (ld_data[31:16] == 16'h0));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!addr_err && wr_en == '0 && ld_data == '0));

    // R11
    load_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_store) |=> (wr_en == '0));
endmodule

bind ba_lsu_aligner ba_lsu_aligner_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_is_store (req_is_store),
    .req_size     (req_size),
    .req_unsigned (req_unsigned),
    .req_offset   (req_offset),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .ld_data      (ld_data),
    .addr_err     (addr_err)
);

// File: tb/test_ba_lsu_aligner.sv
// Bench for ba_lsu_aligner: directed corners, then seeded random requests,
// each compared with a reference model written from the requirements.
module test_ba_lsu_aligner;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_is_store, req_unsigned;
    logic [1:0]  req_size, req_offset;
    logic [31:0] st_data, rd_word;
    logic [3:0]  wr_en;
    logic [31:0] wr_data, ld_data;
    logic        addr_err;
    int          vectors = 0;
    int          miscompares = 0;

    always #10 clk = ~clk;

    ba_lsu_aligner i_ba_lsu_aligner (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_store(req_is_store),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_offset(req_offset),
        .st_data(st_data), .rd_word(rd_word), .wr_en(wr_en), .wr_data(wr_data),
        .ld_data(ld_data), .addr_err(addr_err)
    );

    function automatic logic m_err(logic v, logic [1:0] sz, logic [1:0] off);
        return v && (sz == 2'd3 || (sz == 2'd1 && off[0]) || (sz == 2'd2 && off != 2'd0));
    endfunction

    function automatic logic [3:0] m_we(logic v, logic st, logic [1:0] sz, logic [1:0] off);
        if (!v || !st || m_err(v, sz, off)) return 4'b0;
        case (sz)
            2'd0:    return 4'b1000 >> off;
            2'd1:    return (off == 2'd0) ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] m_wd(logic [1:0] sz, logic [31:0] d);
        case (sz)
            2'd0:    return {4{d[7:0]}};
            2'd1:    return {2{d[15:0]}};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] m_ld(logic v, logic st, logic [1:0] sz, logic un,
                                         logic [1:0] off, logic [31:0] rw);
        logic [7:0]  b;
        logic [15:0] h;
        if (!v || st || m_err(v, sz, off)) return 32'h0;
        b = rw[31 - 8*off -: 8];
        h = off[1] ? rw[15:0] : rw[31:16];
        case (sz)
            2'd0:    return un ? {24'h0, b} : {{24{b[7]}}, b};
            2'd1:    return un ? {16'h0, h} : {{16{h[15]}}, h};
            default: return rw;
        endcase
    endfunction

    function automatic string tag_of(logic v, logic st, logic [1:0] sz, logic un, logic [1:0] off);
        if (!v) return "R10";
        if (m_err(v, sz, off)) return "R6";
        if (st) return (sz == 2'd0) ? "R2" : (sz == 2'd1) ? "R3" : "R4";
        if (sz == 2'd0) return un ? "R8" : "R7";
        if (sz == 2'd1) return "R9";
        return "R11";
    endfunction

    // drive at a falling edge, sample at the next falling edge
    task automatic apply(input logic v, input logic st, input logic [1:0] sz, input logic un,
                         input logic [1:0] off, input logic [31:0] d, input logic [31:0] rw,
                         input string tag);
        logic [3:0]  e_we;
        logic [31:0] e_wd, e_ld;
        logic        e_err;
        @(negedge clk);
        req_valid = v; req_is_store = st; req_size = sz; req_unsigned = un;
        req_offset = off; st_data = d; rd_word = rw;
        e_we = m_we(v, st, sz, off);
        e_wd = m_wd(sz, d);
        e_ld = m_ld(v, st, sz, un, off, rw);
        e_err = m_err(v, sz, off);
        @(negedge clk);
        vectors++;
        if (wr_en !== e_we || wr_data !== e_wd || ld_data !== e_ld || addr_err !== e_err) begin
            miscompares++;
            $display("FAIL %s: we=%h/%h wd=%h/%h ld=%h/%h err=%b/%b (actual/expected)",
                     tag, wr_en, e_we, wr_data, e_wd, ld_data, e_ld, addr_err, e_err);
        end
    endtask

    task automatic check_reset_state();
        vectors++;
        if (wr_en !== 4'h0 || wr_data !== 32'h0 || ld_data !== 32'h0 || addr_err !== 1'b0) begin
            miscompares++;
            $display("FAIL R1: we=%h wd=%h ld=%h err=%b expected all zero",
                     wr_en, wr_data, ld_data, addr_err);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL R10: watchdog expired, actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        rst_n = 1'b0;
        req_valid = 1'b1; req_is_store = 1'b1; req_size = 2'd2; req_unsigned = 1'b0;
        req_offset = 2'd0; st_data = 32'hFFFF_FFFF; rd_word = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check_reset_state();                              // R1
        @(negedge clk);
        rst_n = 1'b1;

        // R2 byte stores, one strobe per offset; R5 replication
        for (int k = 0; k < 4; k++)
            apply(1, 1, 2'd0, 0, 2'(k), 32'h1234_56A5, 32'h0, "R2");
        // R3 half stores
        apply(1, 1, 2'd1, 0, 2'd0, 32'hDEAD_BEEF, 32'h0, "R3");
        apply(1, 1, 2'd1, 0, 2'd2, 32'hDEAD_BEEF, 32'h0, "R3");
        // R4 word store, R5 pass-through
        apply(1, 1, 2'd2, 0, 2'd0, 32'hCAFE_F00D, 32'h0, "R4");
        apply(0, 1, 2'd1, 0, 2'd0, 32'h0000_8001, 32'h0, "R5");
        // R6 misaligned and reserved
        apply(1, 1, 2'd1, 0, 2'd1, 32'h1111_2222, 32'h0, "R6");
        apply(1, 0, 2'd1, 0, 2'd3, 32'h0, 32'h8123_8456, "R6");
        for (int k = 1; k < 4; k++)
            apply(1, 1, 2'd2, 0, 2'(k), 32'hAAAA_5555, 32'h0, "R6");
        apply(1, 0, 2'd3, 1, 2'd0, 32'h0, 32'h7777_7777, "R6");
        // R7 signed byte loads, each lane negative
        for (int k = 0; k < 4; k++)
            apply(1, 0, 2'd0, 0, 2'(k), 32'h0, 32'h8091_A2F3, "R7");
        apply(1, 0, 2'd1, 0, 2'd2, 32'h0, 32'h1234_9ABC, "R7");
        // R8 unsigned loads
        apply(1, 0, 2'd0, 1, 2'd1, 32'h0, 32'h00F0_0000, "R8");
        apply(1, 0, 2'd1, 1, 2'd0, 32'h0, 32'hF00D_0000, "R8");
        // R9 half-word lane selection, word load
        apply(1, 0, 2'd1, 0, 2'd0, 32'h0, 32'h7ABC_8DEF, "R9");
        apply(1, 0, 2'd1, 0, 2'd2, 32'h0, 32'h7ABC_1DEF, "R9");
        apply(1, 0, 2'd2, 0, 2'd0, 32'h0, 32'h8765_4321, "R9");
        // R10 idle request
        apply(0, 0, 2'd0, 0, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10");
        // R11 loads with store data present, store with read word present
        apply(1, 0, 2'd2, 0, 2'd0, 32'hFFFF_FFFF, 32'h0102_0304, "R11");
        apply(1, 1, 2'd0, 0, 2'd3, 32'h0000_0042, 32'hFFFF_FFFF, "R11");

        for (int n = 0; n < 3000; n++) begin
            logic       v, st, un;
            logic [1:0] sz, off;
            v   = ($urandom % 8) != 0;
            st  = 1'($urandom);
            un  = 1'($urandom);
            sz  = 2'($urandom);
            off = 2'($urandom);
            apply(v, st, sz, un, off, $urandom, $urandom, tag_of(v, st, sz, un, off));
        end

        // R1 reset in the middle of traffic
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule